// File: doc/BRIEF.md
# Configurable-Format Serial Receiver

This block turns an asynchronous serial line into parallel characters. The line is retimed by a short synchroniser chain. It is then examined once per pulse of a sample-enable input that runs at a fixed multiple of the bit rate, 16 by default. Static configuration inputs select the character shape: a 2-bit word-length code for 5 to 8 data bits, a parity enable, and the parity sense. Trailing stop bits beyond the first look like an idle line to the receiver, so the stop-bit count needs no input.

When a character completes, the assembled word enters a holding register. The word is zero-extended to 8 bits. A ready flag is raised, and three separate error flags are loaded at the same time: parity mismatch, stop position sampled low, and a completed character that replaced an unread one. The consumer pulses a read-acknowledge to drop the ready flag. A start edge that does not last to mid-bit is dropped without producing a character.

Top module: `uart_rx_fmt`

## Requirements
- R1: `cfg_wlen` code c selects 5+c data bits. Data bits arrive least significant first. `rx_data` bit i holds data bit i, and bits at and above 5+c read 0.
- R2: After a falling edge, the line is checked again on the 8th sample tick following detection. If it is high, the receiver returns to idle and no character, flag or data change results.
- R3: Each data, parity and stop position is sampled 16 sample ticks after the previous sample. Clock cycles without `sample_en` do not advance the receiver, so a half-rate `sample_en` with 32 clocks per bit decodes the same characters.
- R4: With `cfg_par_en`=0 no parity bit is expected and `err_parity` reads 0. With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over data plus parity, `cfg_par_odd`=1 expects an odd count, and a mismatch sets `err_parity`.
- R5: `err_frame` is set when the first stop position is sampled low. The data is still delivered.
- R6: When a character completes while `rx_ready` is 1 and `rd_ack` is 0, `err_overrun` is set and `rx_data` takes the new character. A completion with `rx_ready` at 0 clears `err_overrun`.
- R7: `rd_ack` clears `rx_ready` on the next clock. When `rd_ack` coincides with a completion, the completion wins and no overrun is reported.
- R8: `rx_data` and all three error flags change only when a character completes, together with the rise of `rx_ready`. They hold their values across `rd_ack` until the next completion.
- R9: Only the first stop bit is checked. The receiver rearms after it, so a new start bit may follow a single stop bit directly.
- R10: During and after reset `rx_ready`, `rx_data` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample tick at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_wlen | input | 2 | Word-length code, 5+code data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_ack | input | 1 | Read acknowledge, clears ready |
| rx_data | output | 8 | Received word, zero-extended |
| rx_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Parity mismatch on last character |
| err_frame | output | 1 | Stop position low on last character |
| err_overrun | output | 1 | Last character replaced an unread one |

## Verification
The main function is swept over every word length, parity setting and parity sense, with sixteen words per configuration that include all-zeros, all-ones and mixed patterns. A misplaced bit index, a wrong pad or an inverted parity sense therefore shows up in some configuration. Separate patterns target the errors and the false start. A corrupted parity bit tells a parity fault apart from data loss. A low stop bit tells a framing fault apart from a shifted sample point. Two unread characters in a row show overrun and overwrite. A short low glitch shows start rejection. Half-rate sample ticks tell tick counting apart from clock counting, and back-to-back characters with one stop bit show rearming.

// File: rtl/uart_rx_fmt_pkg.sv
package uart_rx_fmt_pkg;

   typedef enum logic [2:0] {
      RXS_IDLE   = 3'd0,
      RXS_START  = 3'd1,
      RXS_DATA   = 3'd2,
      RXS_PARITY = 3'd3,
      RXS_STOP   = 3'd4
   } rx_state_e;

   // error status captured with each completed character
   typedef struct packed {
      logic par_err;
      logic frm_err;
   } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RESET_VAL;
            else        pipe[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RESET_VAL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_rx_fmt_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned MIN_BITS   = 5,
   parameter int unsigned MAX_BITS   = 8,
   parameter int unsigned WLEN_W     = 2,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic [WLEN_W-1:0]   wlen,
   input  logic                par_en,
   input  logic                par_odd,
   output logic                done,
   output logic [MAX_BITS-1:0] word,
   output rx_flags_t           flags
);

   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam int unsigned IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE/2 - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("uart_rx_engine: OVERSAMPLE must be even and at least 4");
   end
   if (MIN_BITS < 1 || MIN_BITS + (1 << WLEN_W) - 1 > MAX_BITS) begin : g_bad_len
      $error("uart_rx_engine: word-length code range exceeds MAX_BITS");
   end

   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [IDX_W-1:0]     last_idx;
   logic [MAX_BITS-1:0]  shreg;
   logic                 par_acc;
   logic                 par_bad;
   logic                 line_prev;
   logic                 par_active;
   logic                 at_mid;
   logic                 at_last;

   // parity hardware may be left out; the enable then reads as off
   if (HAS_PARITY) begin : g_par
      assign par_active = par_en;
   end else begin : g_nopar
      logic unused_par;
      assign unused_par = par_en ^ par_odd;
      assign par_active = 1'b0;
   end

   assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(wlen);
   assign at_mid   = (cnt == CNT_MID);
   assign at_last  = (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RXS_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         par_bad   <= 1'b0;
         line_prev <= 1'b1;
         done      <= 1'b0;
         word      <= '0;
         flags     <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            line_prev <= line;
            unique case (state)
               RXS_IDLE: begin
                  if (line_prev && !line) begin
                     state <= RXS_START;
                     cnt   <= '0;
                  end
               end
               RXS_START: begin
                  if (at_mid) begin
                     cnt <= '0;
                     if (line) begin
                        state <= RXS_IDLE;          // glitch, not a start
                     end else begin
                        state   <= RXS_DATA;
                        idx     <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_DATA: begin
                  if (at_last) begin
                     cnt        <= '0;
                     shreg[idx] <= line;
                     par_acc    <= par_acc ^ line;
                     if (idx == last_idx) begin
                        state <= par_active ? RXS_PARITY : RXS_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_PARITY: begin
                  if (at_last) begin
                     cnt     <= '0;
                     par_bad <= par_acc ^ line ^ par_odd;
                     state   <= RXS_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_STOP: begin
                  if (at_last) begin
                     cnt           <= '0;
                     done          <= 1'b1;
                     word          <= shreg;
                     flags.frm_err <= ~line;
                     flags.par_err <= par_active & par_bad;
                     state         <= RXS_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RXS_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
   import uart_rx_fmt_pkg::*;
#(
   parameter int unsigned MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [MAX_BITS-1:0] word,
   input  rx_flags_t           flags,
   input  logic                rd_ack,
   output logic [MAX_BITS-1:0] data_q,
   output logic                ready_q,
   output logic                par_err_q,
   output logic                frm_err_q,
   output logic                ovr_err_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         ready_q   <= 1'b0;
         par_err_q <= 1'b0;
         frm_err_q <= 1'b0;
         ovr_err_q <= 1'b0;
      end else if (done) begin
         // a read in the same cycle counts as taken before the new word
         data_q    <= word;
         ready_q   <= 1'b1;
         par_err_q <= flags.par_err;
         frm_err_q <= flags.frm_err;
         ovr_err_q <= ready_q & ~rd_ack;
      end else if (rd_ack) begin
         ready_q <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rx_fmt.sv
module uart_rx_fmt
   import uart_rx_fmt_pkg::*;
#(
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_BITS    = 5,
   parameter int unsigned MAX_BITS    = 8,
   parameter int unsigned WLEN_W      = 2,
   parameter bit          HAS_PARITY  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_en,
   input  logic                rxd,
   input  logic [WLEN_W-1:0]   cfg_wlen,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                rd_ack,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_ready,
   output logic                err_parity,
   output logic                err_frame,
   output logic                err_overrun
);

   logic                line_s;
   logic                char_done;
   logic [MAX_BITS-1:0] char_word;
   rx_flags_t           char_flags;

   uart_rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rxd),
      .q_sync  (line_s)
   );

   uart_rx_engine #(
      .OVERSAMPLE (OVERSAMPLE),
      .MIN_BITS   (MIN_BITS),
      .MAX_BITS   (MAX_BITS),
      .WLEN_W     (WLEN_W),
      .HAS_PARITY (HAS_PARITY)
   ) i_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sample_en),
      .line    (line_s),
      .wlen    (cfg_wlen),
      .par_en  (cfg_par_en),
      .par_odd (cfg_par_odd),
      .done    (char_done),
      .word    (char_word),
      .flags   (char_flags)
   );

   uart_rx_hold #(
      .MAX_BITS (MAX_BITS)
   ) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (char_done),
      .word      (char_word),
      .flags     (char_flags),
      .rd_ack    (rd_ack),
      .data_q    (rx_data),
      .ready_q   (rx_ready),
      .par_err_q (err_parity),
      .frm_err_q (err_frame),
      .ovr_err_q (err_overrun)
   );

endmodule

// File: rtl/uart_rx_fmt_chk.sv
module uart_rx_fmt_chk #(
   parameter int unsigned MAX_BITS = 8,
   parameter int unsigned WLEN_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_ack,
   input logic                done,
   input logic [WLEN_W-1:0]   cfg_wlen,
   input logic                cfg_par_en,
   input logic [MAX_BITS-1:0] rx_data,
   input logic                rx_ready,
   input logic                err_parity,
   input logic                err_frame,
   input logic                err_overrun
);

   assert_ready_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_ready);

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rd_ack && !done) |=> !rx_ready);

   assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_ready && !rd_ack) |=> err_overrun);

   assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rx_ready) |=> !err_overrun);

   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable({rx_data, err_parity, err_frame, err_overrun}));

   assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_wlen == '0) |=> (rx_data[MAX_BITS-1:5] == '0));

   assert_parity_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cfg_par_en) |=> !err_parity);

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (!rx_ready || $isunknown(rx_ready));
      end
   end

endmodule

bind uart_rx_fmt uart_rx_fmt_chk #(
   .MAX_BITS (MAX_BITS),
   .WLEN_W   (WLEN_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_ack      (rd_ack),
   .done        (char_done),
   .cfg_wlen    (cfg_wlen),
   .cfg_par_en  (cfg_par_en),
   .rx_data     (rx_data),
   .rx_ready    (rx_ready),
   .err_parity  (err_parity),
   .err_frame   (err_frame),
   .err_overrun (err_overrun)
);

// File: tb/test_uart_rx_fmt.sv
module test_uart_rx_fmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b1;
   logic       half_rate = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       rd_ack = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic       err_parity;
   logic       err_frame;
   logic       err_overrun;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   always @(negedge clk) sample_en <= half_rate ? ~sample_en : 1'b1;

   uart_rx_fmt i_uart_rx_fmt (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_en   (sample_en),
      .rxd         (rxd),
      .cfg_wlen    (cfg_wlen),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .rd_ack      (rd_ack),
      .rx_data     (rx_data),
      .rx_ready    (rx_ready),
      .err_parity  (err_parity),
      .err_frame   (err_frame),
      .err_overrun (err_overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int len);
      rxd = v;
      repeat (len) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] val, input int nbits, input bit pen,
                             input bit podd, input bit bad_par, input bit bad_stop,
                             input int bitlen);
      logic p;
      p = 1'b0;
      for (int i = 0; i < nbits; i++) p ^= val[i];
      drive(1'b0, bitlen);
      for (int i = 0; i < nbits; i++) drive(val[i], bitlen);
      if (pen) drive(p ^ podd ^ bad_par, bitlen);
      drive(!bad_stop, bitlen);
      rxd = 1'b1;
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   function automatic logic [7:0] mask_of(input int nbits);
      return 8'((1 << nbits) - 1);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int nb;
      repeat (4) @(negedge clk);
      // R10: reset state
      chk("R10 ready", rx_ready, 0);
      chk("R10 data", rx_data, 0);
      chk("R10 flags", {err_parity, err_frame, err_overrun}, 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);

      // R1 R4 R3: sweep every format with sixteen words
      for (int w = 0; w < 4; w++) begin
         for (int pe = 0; pe < 2; pe++) begin
            for (int po = 0; po < 2; po++) begin
               cfg_wlen = 2'(w); cfg_par_en = 1'(pe); cfg_par_odd = 1'(po);
               nb = 5 + w;
               for (int k = 0; k < 16; k++) begin
                  v = (k == 15) ? 8'hFF : 8'((k * 77) ^ (k << 4));
                  send_frame(v, nb, 1'(pe), 1'(po), 1'b0, 1'b0, 16);
                  chk("R1 data", rx_data, v & mask_of(nb));
                  chk("R3 ready", rx_ready, 1);
                  chk("R4 parity ok", err_parity, 0);
                  chk("R5 frame ok", err_frame, 0);
                  chk("R6 no overrun", err_overrun, 0);
                  ack();
                  chk("R7 ack clears", rx_ready, 0);
               end
            end
         end
      end

      // R4: corrupted parity, both senses, 7-bit word
      for (int po = 0; po < 2; po++) begin
         cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'(po);
         send_frame(8'h5A, 7, 1'b1, 1'(po), 1'b1, 1'b0, 16);
         chk("R4 parity err", err_parity, 1);
         chk("R4 data kept", rx_data, 8'h5A);
         ack();
         chk("R8 parity flag held", err_parity, 1);
         send_frame(8'h33, 7, 1'b1, 1'(po), 1'b0, 1'b0, 16);
         chk("R8 parity flag renewed", err_parity, 0);
         ack();
      end

      // R5: stop position low
      cfg_wlen = 2'd3; cfg_par_en = 1'b0;
      send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
      drive(1'b1, 32);
      chk("R5 frame err", err_frame, 1);
      chk("R5 data kept", rx_data, 8'hC3);
      ack();
      chk("R8 frame flag held", err_frame, 1);
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R8 frame flag renewed", err_frame, 0);
      ack();

      // R6: two characters without a read
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      send_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R6 overrun", err_overrun, 1);
      chk("R6 overwrite", rx_data, 8'h22);
      ack();
      send_frame(8'h44, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R6 overrun cleared", err_overrun, 0);
      ack();

      // R2: short glitch is not a start
      drive(1'b0, 6);
      drive(1'b1, 200);
      chk("R2 no char", rx_ready, 0);
      chk("R2 data untouched", rx_data, 8'h44);
      send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R2 next char", rx_data, 8'h96);
      ack();

      // R9: back-to-back characters with a single stop bit
      cfg_wlen = 2'd1;
      send_frame(8'h2D, 6, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R9 first char", rx_data, 8'h2D);
      send_frame(8'h12, 6, 1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R9 second char", rx_data, 8'h12);
      chk("R9 second overrun", err_overrun, 1);
      ack();
      drive(1'b1, 32);

      // R3: half-rate ticks, 32 clocks per bit
      half_rate = 1'b1;
      cfg_wlen = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      drive(1'b1, 32);
      for (int k = 0; k < 4; k++) begin
         v = 8'(8'hA7 + k * 8'h31);
         send_frame(v, 8, 1'b1, 1'b1, 1'b0, 1'b0, 32);
         chk("R3 half rate data", rx_data, v);
         chk("R3 half rate parity", err_parity, 0);
         ack();
      end
      half_rate = 1'b0;

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule